// File: doc/BRIEF.md
# Four-Result Conversion Sequencer with Limit Checking

This block drives one external 8-bit converter that has four multiplexed inputs. It issues a single-cycle start pulse together with a channel select. It then waits for the converter's completion strobe and stores each finished sample in one of four result registers. Three run modes are offered: one conversion on a chosen input, an endless repeat on that input, and an alternating pair scan. The pair scan fills all four result registers from two chosen inputs and reports completion only once the whole set is finished.

Every finished sample can also be compared against a programmable lower/upper limit pair. The comparison can flag a sample that lies inside the window or one that lies outside it. In outside mode the converter may present its upper nibble early, and the block raises the limit flag as soon as that nibble alone settles the outcome. Software sets up the block and collects results through a small register port with sticky flags and a single interrupt line.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every register reads 0x00, `adc_go` is low and `seq_irq` is low.
- R2: Single mode (MODE field 0, or 3) runs exactly one conversion on input A, writes the sample to result register A (addresses 8 to 11 hold results 0 to 3), sets the done flag (FLAG bit 0), and the GO readback (CTRL bit 2) returns to 0.
- R3: Pair mode (MODE 2) runs four conversions with inputs A, B, A, B and writes them to results 0, 1, 2, 3 in that order. Input A is CHAN bits 1:0 and input B is CHAN bits 3:2.
- R4: In pair mode the done flag is set only when the fourth conversion of the set completes, never after the first three.
- R5: Loop mode (MODE 1) restarts on input A right after each completion and sets the done flag after every conversion. Writing CTRL with GO=0 lets the conversion in flight finish and store its sample, and then no further start is issued.
- R6: A CTRL write with GO=1 while a run is in progress is ignored. The run keeps its mode, order and conversion count.
- R7: With limit checking on (CTRL bit 4) and inside mode (CTRL bit 5 = 0), the limit flag (FLAG bit 1) is set when LOW (addr 2) <= sample <= HIGH (addr 3).
- R8: With limit checking on and outside mode (CTRL bit 5 = 1), the limit flag is set when sample < LOW or sample > HIGH.
- R9: In outside mode, when `adc_hi_valid` presents an upper nibble that is strictly below LOW's upper nibble or strictly above HIGH's upper nibble, the limit flag is set in the next cycle, before `adc_done`. An upper nibble equal to either limit's nibble defers the decision to the full sample. Inside mode never decides early.
- R10: Flags (address 4) are sticky and reading them clears nothing. A written 0 bit clears its flag and a written 1 bit leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R11: `seq_irq` is high when (done flag AND done-interrupt enable, CTRL bit 3) OR the limit flag is set.
- R12: `adc_go` is high for exactly one cycle, in the cycle after a start is accepted or a restart is decided, and `adc_sel` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from address) |
| adc_go | output | 1 | Conversion start pulse |
| adc_sel | output | 2 | Converter input select |
| adc_hi_valid | input | 1 | Upper nibble of `adc_data` is valid (early strobe) |
| adc_done | input | 1 | Conversion finished, `adc_data` holds the sample |
| adc_data | input | 8 | Sample from converter |
| seq_irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the converter handshake on every cycle. It checks that the start strobe is a lone pulse issued only while a run is active, that the select is held between starts, that no start appears during an unanswered conversion, that result writes coincide with an accepted completion, and that a hardware flag set always survives a simultaneous clearing write. The bench's scenarios are the only evidence for ordering and data. These cover the A/B/A/B interleave and its deferred done flag, the loop stop, the full 256-value sweep of both window modes against arithmetic limits, and the early-nibble decision observed in the cycles before the completion strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_PAIR = 2'd2,
    MODE_RSVD = 2'd3
  } seq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  // register addresses
  localparam int ADR_CTRL = 0;
  localparam int ADR_CHAN = 1;
  localparam int ADR_LOW  = 2;
  localparam int ADR_HIGH = 3;
  localparam int ADR_FLAG = 4;
  localparam int ADR_RES  = 8;

  // CTRL bit positions
  localparam int CB_GO   = 2;
  localparam int CB_DIEN = 3;
  localparam int CB_LEN  = 4;
  localparam int CB_LOUT = 5;

  // FLAG bit positions
  localparam int FB_DONE = 0;
  localparam int FB_LIM  = 1;

  // conversions per pair-scan set minus one
  localparam int PAIR_LAST = 3;

endpackage

// File: rtl/adc_seq_rstsync.sv
module adc_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_seq_limit.sv
module adc_seq_limit #(
  parameter int DW      = 8,
  parameter int EARLY_W = 4
) (
  input  logic          chk_en,
  input  logic          outside,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  input  logic          nib_valid,
  input  logic [DW-1:0] nib_data,
  input  logic          full_valid,
  input  logic [DW-1:0] full_data,
  output logic          lim_set
);
  localparam int TOP = DW - 1;
  localparam int BOT = DW - EARLY_W;

  logic in_window;
  logic full_hit;
  logic early_hit;

  always_comb begin
    in_window = (full_data >= lim_lo) && (full_data <= lim_hi);
    full_hit  = outside ? !in_window : in_window;
    early_hit = outside &&
                ((nib_data[TOP:BOT] < lim_lo[TOP:BOT]) ||
                 (nib_data[TOP:BOT] > lim_hi[TOP:BOT]));
    lim_set   = chk_en && ((full_valid && full_hit) || (nib_valid && early_hit));
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  seq_mode_e        mode_in,
  input  logic [SEL_W-1:0] chan_a,
  input  logic [SEL_W-1:0] chan_b,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [SEL_W-1:0] conv_chan,
  output logic             busy,
  output logic             done_acc,
  output logic             res_we,
  output logic [SEL_W-1:0] res_sel,
  output logic             set_done
);
  seq_state_e       state_q, state_d;
  seq_mode_e        mode_q, mode_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic [SEL_W-1:0] chan_q, chan_d;
  logic             cont_q, cont_d;
  logic             go_q, go_d;
  logic             pair;
  logic             final_conv;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    idx_d    = idx_q;
    chan_d   = chan_q;
    cont_d   = cont_q;
    go_d     = 1'b0;
    pair     = (mode_q == MODE_PAIR);
    done_acc = (state_q == ST_WAIT) && conv_done && !go_q;
    if (pair) final_conv = (idx_q == SEL_W'(PAIR_LAST));
    else      final_conv = !((mode_q == MODE_LOOP) && cont_q && !stop_req);

    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_WAIT;
          mode_d  = mode_in;
          idx_d   = '0;
          cont_d  = 1'b1;
          chan_d  = chan_a;
          go_d    = 1'b1;
        end
      end
      ST_WAIT: begin
        if (stop_req) cont_d = 1'b0;
        if (done_acc) begin
          if (final_conv) begin
            state_d = ST_IDLE;
            cont_d  = 1'b0;
          end else begin
            go_d = 1'b1;
            if (pair) begin
              idx_d  = idx_q + 1'b1;
              chan_d = idx_d[0] ? chan_b : chan_a;
            end else begin
              chan_d = chan_a;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ONCE;
      idx_q   <= '0;
      chan_q  <= '0;
      cont_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      idx_q   <= idx_d;
      chan_q  <= chan_d;
      cont_q  <= cont_d;
      go_q    <= go_d;
    end
  end

  assign conv_start = go_q;
  assign conv_chan  = chan_q;
  assign busy       = (state_q == ST_WAIT);
  assign res_we     = done_acc;
  assign res_sel    = pair ? idx_q : chan_q;
  assign set_done   = done_acc && (!pair || (idx_q == SEL_W'(PAIR_LAST)));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             busy,
  input  logic             res_we,
  input  logic [SEL_W-1:0] res_sel,
  input  logic [DW-1:0]    res_data,
  input  logic             set_done,
  input  logic             set_lim,
  output seq_mode_e        mode,
  output logic             lim_en,
  output logic             lim_out,
  output logic [SEL_W-1:0] chan_a,
  output logic [SEL_W-1:0] chan_b,
  output logic [DW-1:0]    lim_lo,
  output logic [DW-1:0]    lim_hi,
  output logic             start_req,
  output logic             stop_req,
  output logic             flag_done,
  output logic             flag_lim,
  output logic             irq
);
  localparam int            NRES = 1 << SEL_W;
  localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);
  localparam logic [AW-1:0] A_CHAN = AW'(ADR_CHAN);
  localparam logic [AW-1:0] A_LOW  = AW'(ADR_LOW);
  localparam logic [AW-1:0] A_HIGH = AW'(ADR_HIGH);
  localparam logic [AW-1:0] A_FLAG = AW'(ADR_FLAG);
  localparam logic [AW-1:0] A_RES  = AW'(ADR_RES);

  logic [1:0]         mode_q;
  logic               dien_q, len_q, lout_q;
  logic [SEL_W-1:0]   cha_q, chb_q;
  logic [DW-1:0]      lo_q, hi_q;
  logic               fdone_q, fdone_d;
  logic               flim_q, flim_d;
  logic [DW-1:0]      res_q [NRES];

  logic wr_ctrl, wr_chan, wr_low, wr_high, wr_flag;
  logic rd_res;

  always_comb begin
    wr_ctrl = wr && (addr == A_CTRL);
    wr_chan = wr && (addr == A_CHAN);
    wr_low  = wr && (addr == A_LOW);
    wr_high = wr && (addr == A_HIGH);
    wr_flag = wr && (addr == A_FLAG);
    rd_res  = (addr[AW-1:SEL_W] == A_RES[AW-1:SEL_W]);
  end

  assign start_req = wr_ctrl && wdata[CB_GO] && !busy;
  assign stop_req  = wr_ctrl && !wdata[CB_GO];

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dien_q <= 1'b0;
      len_q  <= 1'b0;
      lout_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= wdata[1:0];
      dien_q <= wdata[CB_DIEN];
      len_q  <= wdata[CB_LEN];
      lout_q <= wdata[CB_LOUT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cha_q <= '0;
      chb_q <= '0;
    end else if (wr_chan) begin
      cha_q <= wdata[SEL_W-1:0];
      chb_q <= wdata[2*SEL_W-1:SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (wr_low) lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_q <= '0;
    else if (wr_high) hi_q <= wdata;
  end

  // sticky flags: write-zero clears, hardware set has priority
  always_comb begin
    fdone_d = fdone_q;
    flim_d  = flim_q;
    if (wr_flag) begin
      fdone_d = fdone_q & wdata[FB_DONE];
      flim_d  = flim_q  & wdata[FB_LIM];
    end
    if (set_done) fdone_d = 1'b1;
    if (set_lim)  flim_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdone_q <= 1'b0;
      flim_q  <= 1'b0;
    end else begin
      fdone_q <= fdone_d;
      flim_q  <= flim_d;
    end
  end

  // result registers
  for (genvar g = 0; g < NRES; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   res_q[g] <= '0;
      else if (res_we && (res_sel == SEL_W'(g)))    res_q[g] <= res_data;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_res) begin
      rdata = res_q[addr[SEL_W-1:0]];
    end else begin
      unique case (addr)
        A_CTRL: begin
          rdata[1:0]     = mode_q;
          rdata[CB_GO]   = busy;
          rdata[CB_DIEN] = dien_q;
          rdata[CB_LEN]  = len_q;
          rdata[CB_LOUT] = lout_q;
        end
        A_CHAN: begin
          rdata[SEL_W-1:0]       = cha_q;
          rdata[2*SEL_W-1:SEL_W] = chb_q;
        end
        A_LOW:  rdata = lo_q;
        A_HIGH: rdata = hi_q;
        A_FLAG: begin
          rdata[FB_DONE] = fdone_q;
          rdata[FB_LIM]  = flim_q;
        end
        default: rdata = '0;
      endcase
    end
  end

  assign mode      = seq_mode_e'(wdata[1:0]);
  assign lim_en    = len_q;
  assign lim_out   = lout_q;
  assign chan_a    = cha_q;
  assign chan_b    = chb_q;
  assign lim_lo    = lo_q;
  assign lim_hi    = hi_q;
  assign flag_done = fdone_q;
  assign flag_lim  = flim_q;
  assign irq       = (fdone_q && dien_q) || flim_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int NIN     = 4,
  parameter int EARLY_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  output logic                   adc_go,
  output logic [$clog2(NIN)-1:0] adc_sel,
  input  logic                   adc_hi_valid,
  input  logic                   adc_done,
  input  logic [DW-1:0]          adc_data,
  output logic                   seq_irq
);
  localparam int SEL_W = $clog2(NIN);

  logic             rst_sync_n;
  seq_mode_e        mode_w;
  logic             lim_en, lim_out;
  logic [SEL_W-1:0] chan_a, chan_b;
  logic [DW-1:0]    lim_lo, lim_hi;
  logic             start_req, stop_req;
  logic             seq_busy, done_acc, res_we, set_done, set_lim;
  logic [SEL_W-1:0] res_sel;
  logic             flag_done, flag_lim;
  logic             nib_ok;

  adc_seq_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_seq_regs #(.DW(DW), .AW(AW), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (cfg_wr),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .busy      (seq_busy),
    .res_we    (res_we),
    .res_sel   (res_sel),
    .res_data  (adc_data),
    .set_done  (set_done),
    .set_lim   (set_lim),
    .mode      (mode_w),
    .lim_en    (lim_en),
    .lim_out   (lim_out),
    .chan_a    (chan_a),
    .chan_b    (chan_b),
    .lim_lo    (lim_lo),
    .lim_hi    (lim_hi),
    .start_req (start_req),
    .stop_req  (stop_req),
    .flag_done (flag_done),
    .flag_lim  (flag_lim),
    .irq       (seq_irq)
  );

  adc_seq_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .mode_in    (mode_w),
    .chan_a     (chan_a),
    .chan_b     (chan_b),
    .conv_done  (adc_done),
    .conv_start (adc_go),
    .conv_chan  (adc_sel),
    .busy       (seq_busy),
    .done_acc   (done_acc),
    .res_we     (res_we),
    .res_sel    (res_sel),
    .set_done   (set_done)
  );

  assign nib_ok = seq_busy && !adc_go && adc_hi_valid;

  adc_seq_limit #(.DW(DW), .EARLY_W(EARLY_W)) u_lim (
    .chk_en     (lim_en),
    .outside    (lim_out),
    .lim_lo     (lim_lo),
    .lim_hi     (lim_hi),
    .nib_valid  (nib_ok),
    .nib_data   (adc_data),
    .full_valid (done_acc),
    .full_data  (adc_data),
    .lim_set    (set_lim)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic [SEL_W-1:0] conv_chan,
  input logic             busy,
  input logic             conv_done,
  input logic             res_we,
  input logic             set_done,
  input logic             flag_done
);
  // R12: start is a single-cycle pulse
  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R12: start only during an active run
  p_start_in_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R12: select held while a conversion is outstanding
  p_chan_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && $past(busy)) |-> $stable(conv_chan));

  // R6: no new start while the previous one is unanswered
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(conv_done)) |-> !conv_start);

  // R2: results are written only on an accepted completion
  p_write_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (conv_done && busy));

  // R4: done flag is raised together with a result write
  p_done_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> res_we);

  // R10: hardware set wins over a clearing write
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> flag_done);
endmodule

bind adc_seq_top adc_seq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .conv_start (adc_go),
  .conv_chan  (adc_sel),
  .busy       (seq_busy),
  .conv_done  (adc_done),
  .res_we     (res_we),
  .set_done   (set_done),
  .flag_done  (flag_done)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'd0, A_CHAN = 4'd1, A_LOW = 4'd2,
                         A_HIGH = 4'd3, A_FLAG = 4'd4, A_RES = 4'd8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       adc_go;
  logic [1:0] adc_sel;
  logic       adc_hi_valid;
  logic       adc_done;
  logic [7:0] adc_data;
  logic       seq_irq;

  int         checks = 0;
  int         errors = 0;
  int         cnt = 0;
  int         nib_dly = 1;
  int         done_dly = 2;
  logic [7:0] vals [64];
  logic [1:0] chans [64];

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .adc_go(adc_go),
    .adc_sel(adc_sel), .adc_hi_valid(adc_hi_valid), .adc_done(adc_done),
    .adc_data(adc_data), .seq_irq(seq_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 500; i++) begin
      rd(A_CTRL, d);
      if (!d[2]) return;
    end
    chk("run ends", 1, 0);
  endtask

  task automatic wait_cnt(input int n);
    while (cnt < n) @(negedge clk);
  endtask

  // converter model
  task automatic serve();
    logic [7:0] v;
    v = vals[cnt % 64];
    chans[cnt % 64] = adc_sel;
    repeat (nib_dly) @(negedge clk);
    adc_hi_valid = 1'b1; adc_data = {v[7:4], 4'h0};
    @(negedge clk);
    adc_hi_valid = 1'b0;
    repeat (done_dly) @(negedge clk);
    adc_done = 1'b1; adc_data = v;
    @(negedge clk);
    adc_done = 1'b0;
    cnt++;
  endtask

  initial begin
    adc_hi_valid = 1'b0; adc_done = 1'b0; adc_data = '0;
    forever begin
      @(negedge clk);
      while (adc_go === 1'b1) serve();
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s, c, n;
    logic ex;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < 64; i++) vals[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    foreach (vals[i]) if (i < 12) begin
      rd(4'(i), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 adc_go", adc_go, 0);
    chk("R1 irq", seq_irq, 0);

    // R2/R12/R11 single conversions on each input
    for (int ch = 0; ch < 4; ch++) begin
      wr(A_CHAN, 8'(ch));
      s = cnt;
      vals[s % 64] = 8'(8'h1B + ch * 37);
      wr(A_CTRL, 8'h0C);
      chk("R12 go pulse high", adc_go, 1);
      chk("R12 select", adc_sel, ch);
      @(negedge clk);
      chk("R12 go pulse low", adc_go, 0);
      chk("R12 select held", adc_sel, ch);
      wait_idle();
      rd(A_RES + 4'(ch), d);
      chk("R2 result register", d, 8'(8'h1B + ch * 37));
      chk("R2 one conversion", cnt, s + 1);
      chk("R2 input used", chans[s % 64], ch);
      rd(A_FLAG, d);
      chk("R2 done flag", d[0], 1);
      chk("R11 irq with enable", seq_irq, 1);
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, d);
      chk("R10 write zero clears", d, 0);
    end

    // R11 done flag without enable gives no irq
    vals[cnt % 64] = 8'h33;
    wr(A_CTRL, 8'h04);
    wait_idle();
    rd(A_FLAG, d);
    chk("R11 flag set", d[0], 1);
    chk("R11 no irq when disabled", seq_irq, 0);
    wr(A_FLAG, 8'h00);

    // R3/R4/R6 pair scan, A=1 B=3
    wr(A_CHAN, 8'h0D);
    s = cnt;
    vals[(s)   % 64] = 8'hA1;
    vals[(s+1) % 64] = 8'h5C;
    vals[(s+2) % 64] = 8'h3E;
    vals[(s+3) % 64] = 8'hF0;
    wr(A_CTRL, 8'h0E);
    wait_cnt(s + 1);
    wr(A_CTRL, 8'h0C);
    wait_cnt(s + 3);
    rd(A_FLAG, d);
    chk("R4 no done after three", d[0], 0);
    chk("R4 no irq after three", seq_irq, 0);
    wait_idle();
    rd(A_FLAG, d);
    chk("R4 done after four", d[0], 1);
    chk("R6 restart ignored count", cnt, s + 4);
    rd(A_RES + 4'd0, d); chk("R3 result 0", d, 8'hA1);
    rd(A_RES + 4'd1, d); chk("R3 result 1", d, 8'h5C);
    rd(A_RES + 4'd2, d); chk("R3 result 2", d, 8'h3E);
    rd(A_RES + 4'd3, d); chk("R3 result 3", d, 8'hF0);
    chk("R3 order A", chans[s % 64], 1);
    chk("R3 order B", chans[(s+1) % 64], 3);
    chk("R3 order A again", chans[(s+2) % 64], 1);
    chk("R3 order B again", chans[(s+3) % 64], 3);
    wr(A_FLAG, 8'h00);

    // R5 loop mode on input 0
    wr(A_CHAN, 8'h00);
    s = cnt;
    for (int k = 0; k < 40; k++) vals[(s + k) % 64] = 8'(k * 7 + 3);
    wr(A_CTRL, 8'h05);
    wait_cnt(s + 2);
    rd(A_FLAG, d);
    chk("R5 done flag in loop", d[0], 1);
    wr(A_FLAG, 8'h00);
    c = cnt;
    wait_cnt(c + 1);
    rd(A_FLAG, d);
    chk("R5 done set again", d[0], 1);
    wr(A_CTRL, 8'h01);
    wait_idle();
    n = cnt;
    repeat (30) @(negedge clk);
    chk("R5 no start after stop", cnt, n);
    chk("R5 several runs", (n >= s + 3), 1);
    rd(A_RES, d);
    chk("R5 last sample stored", d, vals[(n - 1) % 64]);
    wr(A_FLAG, 8'h00);

    // R10 flags: reads keep, write one keeps, write zero clears per bit
    wr(A_LOW, 8'h40); wr(A_HIGH, 8'hB0);
    vals[cnt % 64] = 8'h00;
    wr(A_CTRL, 8'h34);
    wait_idle();
    rd(A_FLAG, d); chk("R10 both set", d, 3);
    rd(A_FLAG, d); chk("R10 read keeps", d, 3);
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, d); chk("R10 write one keeps", d, 3);
    wr(A_FLAG, 8'hFE);
    rd(A_FLAG, d); chk("R10 clear done only", d, 2);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); chk("R10 all clear", d, 0);

    // R9 early decision, slow converter
    nib_dly = 2; done_dly = 8;
    vals[cnt % 64] = 8'h3F;
    wr(A_CTRL, 8'h34);
    repeat (3) @(negedge clk);
    rd(A_FLAG, d);
    chk("R9 early flag on low nibble", d[1], 1);
    chk("R9 before completion", d[0], 0);
    wait_idle(); wr(A_FLAG, 8'h00);

    vals[cnt % 64] = 8'hC2;
    wr(A_CTRL, 8'h34);
    repeat (3) @(negedge clk);
    rd(A_FLAG, d);
    chk("R9 early flag on high nibble", d[1], 1);
    wait_idle(); wr(A_FLAG, 8'h00);

    vals[cnt % 64] = 8'hB5;
    wr(A_CTRL, 8'h34);
    repeat (3) @(negedge clk);
    rd(A_FLAG, d);
    chk("R9 equal nibble defers", d[1], 0);
    wait_idle();
    rd(A_FLAG, d);
    chk("R9 deferred decision", d[1], 1);
    wr(A_FLAG, 8'h00);

    vals[cnt % 64] = 8'h45;
    wr(A_CTRL, 8'h14);
    repeat (3) @(negedge clk);
    rd(A_FLAG, d);
    chk("R9 inside mode no early", d[1], 0);
    wait_idle();
    rd(A_FLAG, d);
    chk("R7 inside decided at end", d[1], 1);
    wr(A_FLAG, 8'h00);
    nib_dly = 1; done_dly = 2;

    // R7/R8/R11 exhaustive sweep of both window modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        vals[cnt % 64] = 8'(v);
        wr(A_CTRL, (m != 0) ? 8'h34 : 8'h14);
        wait_idle();
        ex = (m != 0) ? ((v < 8'h40) || (v > 8'hB0)) : ((v >= 8'h40) && (v <= 8'hB0));
        rd(A_FLAG, d);
        chk((m != 0) ? "R8 outside window" : "R7 inside window", d[1], ex);
        chk("R11 irq follows limit flag", seq_irq, ex);
        wr(A_FLAG, 8'h00);
      end
    end

    summary();
    $finish;
  end
endmodule